// File: doc/BRIEF.md
# External Sync Frequency Qualifier

This block decides whether an external synchronisation square wave may take over the switching timebase of a buck controller. The sync wave passes through a two-flop synchroniser; falling edges only are recognised, and the number of system clocks between consecutive recognised falling edges is the measured period. Each measured period is compared against a window built from the locally programmed period. The local period and the phase-alignment delay are run-time inputs in system clock cycles.

The sync is accepted only when its frequency is at or above the local frequency and at most 40% above it. Two in-window periods in a row lock the block. While locked, each accepted edge starts a delay of `alignDelay` clocks, after which a single-cycle pulse resets the phase of the internal ramp. A period outside the window, or a gap of twice the local period with no edge, hands control back to the local oscillator. In light load, every period is judged on its own, and an in-window period yields an interleave trigger after the same delay instead of a phase reset.

Top module: `sync_window_qualifier`

## Requirements
- R1: While `rstN` is low and in the first cycle after it, `syncLocked`, `phaseReset` and `interleaveTrig` are low.
- R2: Only falling edges of `syncIn` count. A falling edge is recognised in the cycle after clock edge n+2, where clock edge n+1 is the first one to sample `syncIn` low after it was high at edge n. The high time of the wave has no effect on the measured period.
- R3: A measured period P, in clocks between two recognised falling edges, is in the window when P <= `localPeriod` and 7*P >= 5*`localPeriod`.
- R4: The first recognised edge after reset or after a fallback only sets a reference. `syncLocked` rises one clock after the edge that ends the second consecutive in-window period. It stays high while further periods are in the window.
- R5: An out-of-window period clears `syncLocked` one clock after its closing edge, and the count of consecutive in-window periods restarts from zero.
- R6: If 2*`localPeriod` clocks pass after a recognised edge with no new edge, `syncLocked` clears on the next clock. The next edge is then only a reference.
- R7: When `lightLoad` is low and the block is locked after an edge, `phaseReset` is high for exactly one cycle, `alignDelay`+1 clocks after the cycle in which the edge is recognised.
- R8: When `lightLoad` is high in the recognising cycle, a single in-window period is enough: `interleaveTrig` pulses for one cycle with the R7 timing, no lock is needed, and `phaseReset` stays low for that edge.
- R9: A pulse still pending is dropped if an out-of-window period or an R6 timeout occurs before it fires.
- R10: `phaseReset` and `interleaveTrig` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| syncIn | input | 1 | External sync square wave, asynchronous |
| localPeriod | input | PER_W | Locally programmed switching period in clocks |
| alignDelay | input | DLY_W | Delay from accepted edge to the phase pulse, in clocks |
| lightLoad | input | 1 | High selects cycle-by-cycle interleave mode |
| syncLocked | output | 1 | High while the external sync drives the timebase |
| phaseReset | output | 1 | One-cycle ramp phase reset pulse |
| interleaveTrig | output | 1 | One-cycle interleave trigger in light load |

## Verification
The checker watches on every cycle that the two pulse outputs never overlap and that a phase reset only appears while locked. It also checks that lock only rises right after an in-window period, and that every out-of-window period and every timeout drops lock on the next clock. The window boundaries, the exact delay from edge to pulse, the indifference to duty cycle, the light-load single-period rule and the cancellation of pending pulses only show up in the bench. There, a cycle-level model built from the requirements is compared against the outputs, both in directed sequences that sit on the window edges and in long random runs.

// File: rtl/syncq_pkg.sv
package syncq_pkg;

  // Observations the datapath hands to the control each cycle
  typedef struct packed {
    logic rawEdge;    // recognised falling edge
    logic validEdge;  // edge that closes a measured period
    logic inWin;      // current count lies inside the window
    logic timeout;    // no edge for twice the local period
  } dpStat_t;

  // Strobes the control hands to the datapath
  typedef struct packed {
    logic launch;     // start the alignment delay
    logic launchLL;   // route the delayed pulse to the interleave output
    logic cancel;     // drop any pending pulse
  } ctlStrb_t;

endpackage

// File: rtl/syncq_datapath.sv
module syncq_datapath
  import syncq_pkg::*;
#(
  parameter int PER_W   = 16,
  parameter int DLY_W   = 12,
  parameter int SYNC_FF = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             syncIn,
  input  logic [PER_W-1:0] localPeriod,
  input  logic [DLY_W-1:0] alignDelay,
  input  ctlStrb_t         strb,
  output dpStat_t          stat,
  output logic             fire,
  output logic             fireLL
);

  localparam int CNT_W = PER_W + 1;       // holds twice the local period
  localparam int MUL_W = CNT_W + 3;       // holds 7 times the count
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // Synchroniser plus one history flop for edge detection
  logic [SYNC_FF:0] chain;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[SYNC_FF-1:0], syncIn};
  end

  logic rawEdge;
  assign rawEdge = chain[SYNC_FF] & ~chain[SYNC_FF-1];

  // Clocks since the last recognised edge, saturating
  logic [CNT_W-1:0] cnt;
  logic             haveRef;
  logic             timeout;
  logic [CNT_W-1:0] twicePer;

  assign twicePer = {localPeriod, 1'b0};
  assign timeout  = haveRef && !rawEdge && (cnt >= twicePer);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      haveRef <= 1'b0;
    end else begin
      if (rawEdge)             cnt <= CNT_W'(1);
      else if (cnt != CNT_MAX) cnt <= cnt + CNT_W'(1);
      if (rawEdge)             haveRef <= 1'b1;
      else if (timeout)        haveRef <= 1'b0;
    end
  end

  // Window: period no longer than local, no shorter than local/1.4
  logic [MUL_W-1:0] cntW, perW;
  logic             inWin;
  always_comb begin
    cntW  = MUL_W'(cnt);
    perW  = MUL_W'(localPeriod);
    inWin = (cntW <= perW) && ((cntW * MUL_W'(7)) >= (perW * MUL_W'(5)));
  end

  assign stat.rawEdge   = rawEdge;
  assign stat.validEdge = rawEdge && haveRef;
  assign stat.inWin     = inWin;
  assign stat.timeout   = timeout;

  // Alignment delay down-counter
  logic [DLY_W-1:0] dly;
  logic             busy;
  logic             modeLL;
  logic             expire;

  assign expire = busy && (dly == '0);
  assign fire   = expire && !modeLL;
  assign fireLL = expire && modeLL;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dly    <= '0;
      busy   <= 1'b0;
      modeLL <= 1'b0;
    end else if (strb.launch) begin
      dly    <= alignDelay;
      busy   <= 1'b1;
      modeLL <= strb.launchLL;
    end else if (strb.cancel) begin
      busy   <= 1'b0;
    end else if (busy) begin
      if (dly == '0) busy <= 1'b0;
      else           dly  <= dly - DLY_W'(1);
    end
  end

endmodule

// File: rtl/syncq_control.sv
module syncq_control
  import syncq_pkg::*;
#(
  parameter int LOCK_CNT = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  dpStat_t  stat,
  input  logic     lightLoad,
  output ctlStrb_t strb,
  output logic     locked
);

  localparam int GOOD_W = $clog2(LOCK_CNT + 1);
  localparam logic [GOOD_W-1:0] GOOD_MAX = GOOD_W'(LOCK_CNT);

  logic [GOOD_W-1:0] good, goodNext;

  always_comb begin
    goodNext = good;
    if (stat.validEdge) begin
      if (!stat.inWin)           goodNext = '0;
      else if (good != GOOD_MAX) goodNext = good + GOOD_W'(1);
    end else if (stat.timeout) begin
      goodNext = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) good <= '0;
    else       good <= goodNext;
  end

  assign locked = (good == GOOD_MAX);

  always_comb begin
    strb.launch   = stat.validEdge && stat.inWin &&
                    (lightLoad || (goodNext == GOOD_MAX));
    strb.launchLL = lightLoad;
    strb.cancel   = (stat.validEdge && !stat.inWin) || stat.timeout;
  end

endmodule

// File: rtl/sync_window_qualifier.sv
module sync_window_qualifier
  import syncq_pkg::*;
#(
  parameter int PER_W    = 16,
  parameter int DLY_W    = 12,
  parameter int SYNC_FF  = 2,
  parameter int LOCK_CNT = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             syncIn,
  input  logic [PER_W-1:0] localPeriod,
  input  logic [DLY_W-1:0] alignDelay,
  input  logic             lightLoad,
  output logic             syncLocked,
  output logic             phaseReset,
  output logic             interleaveTrig
);

  dpStat_t  dpStat;
  ctlStrb_t ctlStrb;

  syncq_datapath #(
    .PER_W  (PER_W),
    .DLY_W  (DLY_W),
    .SYNC_FF(SYNC_FF)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .syncIn     (syncIn),
    .localPeriod(localPeriod),
    .alignDelay (alignDelay),
    .strb       (ctlStrb),
    .stat       (dpStat),
    .fire       (phaseReset),
    .fireLL     (interleaveTrig)
  );

  syncq_control #(
    .LOCK_CNT(LOCK_CNT)
  ) ctl_i (
    .clk      (clk),
    .rstN     (rstN),
    .stat     (dpStat),
    .lightLoad(lightLoad),
    .strb     (ctlStrb),
    .locked   (syncLocked)
  );

endmodule

// File: rtl/sync_window_qualifier_chk.sv
module sync_window_qualifier_chk
  import syncq_pkg::*;
(
  input logic    clk,
  input logic    rstN,
  input logic    syncLocked,
  input logic    phaseReset,
  input logic    interleaveTrig,
  input dpStat_t dpStat
);

  // R10
  pulse_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(phaseReset && interleaveTrig));

  // R7
  phase_needs_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    phaseReset |-> syncLocked);

  // R4
  lock_after_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(syncLocked) |-> $past(dpStat.validEdge && dpStat.inWin));

  // R5
  out_of_window_unlock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dpStat.validEdge && !dpStat.inWin) |=> !syncLocked);

  // R6
  timeout_unlock_chk: assert property (@(posedge clk) disable iff (!rstN)
    dpStat.timeout |=> !syncLocked);

endmodule

bind sync_window_qualifier sync_window_qualifier_chk chk_i (
  .clk           (clk),
  .rstN          (rstN),
  .syncLocked    (syncLocked),
  .phaseReset    (phaseReset),
  .interleaveTrig(interleaveTrig),
  .dpStat        (dpStat)
);

// File: tb/sync_window_qualifier_tb_top.sv
module sync_window_qualifier_tb_top;

  localparam int PER_W = 16;
  localparam int DLY_W = 12;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             syncIn = 1'b0;
  logic [PER_W-1:0] localPeriod = PER_W'(40);
  logic [DLY_W-1:0] alignDelay = DLY_W'(5);
  logic             lightLoad = 1'b0;
  logic             syncLocked, phaseReset, interleaveTrig;

  always #2 clk = ~clk;  // 250 MHz

  sync_window_qualifier #(.PER_W(PER_W), .DLY_W(DLY_W)) dut_i (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .localPeriod(localPeriod),
    .alignDelay(alignDelay), .lightLoad(lightLoad), .syncLocked(syncLocked),
    .phaseReset(phaseReset), .interleaveTrig(interleaveTrig)
  );

  int nChk = 0, nFail = 0;
  bit done = 0;

  // Next values applied together at the end of each tick
  logic nRst = 1'b0, nLL = 1'b0;
  int   nT = 40, nD = 5;

  // Reference model state
  int  cyc = 0;
  bit  h1 = 0, h2 = 0, h3 = 0;
  bit  haveRef = 0, pend = 0, pendLL = 0;
  int  good = 0, lastDet = 0, pendAt = 0;

  // R3: window rule
  function automatic bit winOk(int p, int t);
    return (p <= t) && (7 * p >= 5 * t);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d", req, what, cyc, act, exp);
    end
  endtask

  task automatic tick(bit v);
    bit edgeNow, inw, expF;
    int p;
    @(negedge clk);
    cyc++;
    h3 = h2; h2 = h1; h1 = syncIn;
    if (!rstN) begin
      h1 = 0; h2 = 0; h3 = 0;
      haveRef = 0; pend = 0; good = 0;
      chk("R1", "syncLocked", syncLocked, 0);
      chk("R1", "phaseReset", phaseReset, 0);
      chk("R1", "interleaveTrig", interleaveTrig, 0);
    end else begin
      expF = pend && (cyc == pendAt);
      chk("R2 R3 R4 R5 R6", "syncLocked", syncLocked, (good == 2) ? 1 : 0);
      chk("R7 R9", "phaseReset", phaseReset, (expF && !pendLL) ? 1 : 0);
      chk("R8 R9", "interleaveTrig", interleaveTrig, (expF && pendLL) ? 1 : 0);
      chk("R10", "both pulses", (phaseReset && interleaveTrig) ? 1 : 0, 0);
      if (expF) pend = 0;
      edgeNow = h3 && !h2;  // R2: falling edges only
      if (edgeNow) begin
        if (haveRef) begin
          p   = cyc - lastDet;
          inw = winOk(p, int'(localPeriod));
          if (inw) good = (good < 2) ? good + 1 : 2;
          else begin good = 0; pend = 0; end
          if (inw && (lightLoad || good == 2)) begin
            pend = 1; pendAt = cyc + 1 + int'(alignDelay); pendLL = lightLoad;
          end
        end
        haveRef = 1; lastDet = cyc;
      end else if (haveRef && (cyc - lastDet >= 2 * int'(localPeriod))) begin
        haveRef = 0; good = 0; pend = 0;  // R6, R9
      end
    end
    syncIn      = v;
    rstN        = nRst;
    lightLoad   = nLL;
    localPeriod = PER_W'(nT);
    alignDelay  = DLY_W'(nD);
  endtask

  task automatic wave(int per, int hi);
    for (int i = 0; i < hi; i++) tick(1'b1);
    for (int i = hi; i < per; i++) tick(1'b0);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick(1'b0);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
  endtask

  initial begin
    int t, per, hi;
    void'($urandom(32'd20240517));
    // R1: reset state
    nRst = 1'b0;
    for (int i = 0; i < 4; i++) tick(1'b0);
    nRst = 1'b1;
    tick(1'b0);
    chk("R1", "syncLocked after reset", syncLocked, 0);

    // R3 R4 R5: window boundaries with T=40 (in-window 29..40)
    nT = 40; nD = 5; nLL = 0;
    wave(40, 20); wave(40, 20); wave(40, 20); wave(29, 10);
    wave(28, 10);                 // out: 28 too short
    wave(40, 20); wave(40, 20); wave(41, 20); // 41 too long
    wave(40, 20); wave(40, 20); wave(40, 20);

    // R2: duty cycle extremes, period from falls only
    nT = 35; nD = 3;
    wave(35, 1); wave(35, 34); wave(35, 17); wave(35, 1); wave(30, 29);

    // R6: timeout then reference-only edge
    nT = 40; nD = 4;
    wave(40, 20); wave(40, 20); wave(40, 20);
    idle(100);
    wave(40, 20); wave(40, 20); wave(40, 20);

    // R8: light load, single in-window period gives interleave
    idle(100);
    nLL = 1;
    wave(40, 20); wave(38, 19); wave(50, 25); wave(33, 10);
    nLL = 0;

    // R9: cancellation by short period and by timeout
    idle(100);
    nD = 35;
    wave(40, 20); wave(40, 20); wave(40, 20); wave(20, 10); wave(40, 20);
    idle(100);
    nD = 100;
    wave(40, 20); wave(40, 20); wave(40, 20); idle(130);

    // Random: mixed periods around the window, duty, light load, gaps
    for (int g = 0; g < 10; g++) begin
      t  = 30 + int'($urandom % 31);
      nT = t;
      nD = int'($urandom % t);
      for (int k = 0; k < 45; k++) begin
        per = (t * 5) / 7 - 4 + int'($urandom % (t - (t * 5) / 7 + 9));
        if (per < 2) per = 2;
        hi  = 1 + int'($urandom % (per - 1));
        nLL = (($urandom % 5) == 0);
        wave(per, hi);
        if (($urandom % 25) == 0) idle(2 * t + 5);
      end
    end
    idle(20);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

endmodule